// File: doc/BRIEF.md
# Stack Tag Renamer

This block sits in the front end of a processor whose instructions name no registers: every operand is implicit and comes from the top of an operand stack. The stack does not hold data. It holds the numbers (tags) of physical registers in a flat register file. Each cycle the block takes one instruction class. It tells the pipeline which physical registers hold the operands and which free register receives the result. It then edits its stack of tags to match.

New destinations come from a first-in first-out list of free tags. Retirement gives tags back through a separate release input, which may fire in the same cycle as an allocation. A swap or a rotate only reorders tags. No register contents move, so instructions already in flight keep writing to the registers they were given. If an instruction would take the stack below empty or above its depth, or needs a tag while the free list is empty, the block raises a stall and leaves the stack and the allocation state alone.

The stack resets empty, and the free list resets holding every tag in ascending order, 0 first.

Top module: `stack_renamer`

## Requirements
- R1: After reset the stack depth is 0, the free count equals the number of physical registers (16), and `stall` is low while `op_valid` is low.
- R2: An accepted push (`op_kind` 1) asserts `dst_valid`, presents the tag at the head of the free list on `dst_tag`, makes that tag the new top of stack (`src_a_tag`), and raises the depth by one.
- R3: An accepted pop (`op_kind` 2) lowers the depth by one, and the old second entry becomes the top. The popped tag is not returned to the free list.
- R4: An accepted swap (`op_kind` 3) exchanges the top two tags. Depth and free count stay the same.
- R5: An accepted rotate (`op_kind` 4) moves the third entry to the top and shifts the old top and second entry down by one. Deeper entries and the depth stay the same.
- R6: An accepted binary operation (`op_kind` 5) presents the old top two tags on `src_a_tag`/`src_b_tag`, allocates one tag from the free-list head, and leaves that tag on top with the old third entry beneath it. The depth drops by one.
- R7: `stall` is asserted for a push when the stack is full or the free list is empty, for a pop when the depth is below 1, for a swap or binary operation when the depth is below 2 (a binary operation also when the free list is empty), and for a rotate when the depth is below 3. A stalled instruction changes neither the stack nor the allocation.
- R8: A released tag is appended at the tail of the free list and is allocated only after every tag already queued. The free count rises by one for each release and falls by one for each allocation.
- R9: When an allocation and a release happen in the same cycle, the allocation takes the existing head, the released tag joins the tail, and the free count is unchanged.
- R10: Codes 0, 6 and 7 on `op_kind` are no-ops: no stall, no allocation, no change to the stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An instruction is offered this cycle |
| op_kind | input | 3 | Instruction class: 0 nop, 1 push, 2 pop, 3 swap, 4 rotate, 5 binary op, 6/7 nop |
| rel_valid | input | 1 | Retirement returns a tag this cycle |
| rel_tag | input | 4 | Tag being returned |
| stall | output | 1 | The offered instruction cannot be accepted |
| src_a_tag | output | 4 | Tag at the top of the stack |
| src_b_tag | output | 4 | Tag in the second stack entry |
| dst_tag | output | 4 | Tag at the free-list head, the destination on allocation |
| dst_valid | output | 1 | An allocation is made this cycle |
| stack_depth | output | 4 | Number of valid stack entries |
| free_count | output | 5 | Number of tags in the free list |

## Verification
The assertions assume that retirement never returns a tag while the free list is already full. They also assume that it only returns tags that are neither in the stack nor queued as free, so each tag exists exactly once across the stack, the free list and the in-flight set. The stimulus keeps to this rule. Every tag a pop or binary operation removes goes into a pool in the bench, and releases draw only from that pool, each entry once. As a result the free list can never overflow, and no duplicate tag can appear.

// File: rtl/stk_ren_pkg.sv
package stk_ren_pkg;

   typedef enum logic [2:0] {
      OPK_NOP  = 3'd0,
      OPK_PUSH = 3'd1,
      OPK_POP  = 3'd2,
      OPK_SWAP = 3'd3,
      OPK_ROT  = 3'd4,
      OPK_BIN  = 3'd5
   } opk_e;

endpackage

// File: rtl/ren_op_decode.sv
module ren_op_decode
   import stk_ren_pkg::*;
#(
   parameter int STACK_DEPTH = 8,
   parameter int ROT_SPAN    = 3,
   localparam int DEP_W      = $clog2(STACK_DEPTH + 1)
) (
   input  logic             op_valid,
   input  logic [2:0]       op_kind,
   input  logic [DEP_W-1:0] depth,
   input  logic             fl_empty,
   output logic             stall,
   output logic             do_push,
   output logic             do_pop,
   output logic             do_swap,
   output logic             do_rot,
   output logic             do_bin
);

   logic blocked;
   logic full;

   assign full = (depth == DEP_W'(STACK_DEPTH));

   always_comb begin
      blocked = 1'b0;
      case (opk_e'(op_kind))
         OPK_PUSH: blocked = full || fl_empty;
         OPK_POP:  blocked = (depth < DEP_W'(1));
         OPK_SWAP: blocked = (depth < DEP_W'(2));
         OPK_ROT:  blocked = (depth < DEP_W'(ROT_SPAN));
         OPK_BIN:  blocked = (depth < DEP_W'(2)) || fl_empty;
         default:  blocked = 1'b0;
      endcase
   end

   assign stall   = op_valid && blocked;
   assign do_push = op_valid && !blocked && (op_kind == OPK_PUSH);
   assign do_pop  = op_valid && !blocked && (op_kind == OPK_POP);
   assign do_swap = op_valid && !blocked && (op_kind == OPK_SWAP);
   assign do_rot  = op_valid && !blocked && (op_kind == OPK_ROT);
   assign do_bin  = op_valid && !blocked && (op_kind == OPK_BIN);

endmodule

// File: rtl/ren_free_list.sv
module ren_free_list #(
   parameter int NUM_TAGS = 16,
   localparam int TAG_W   = $clog2(NUM_TAGS),
   localparam int CNT_W   = $clog2(NUM_TAGS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc,
   input  logic             rel_valid,
   input  logic [TAG_W-1:0] rel_tag,
   output logic [TAG_W-1:0] head_tag,
   output logic [CNT_W-1:0] count
);

   generate
      if ((1 << TAG_W) != NUM_TAGS) begin : g_bad_size
         $error("ren_free_list: NUM_TAGS must be a power of two");
      end
   endgenerate

   logic [TAG_W-1:0] slot [NUM_TAGS];
   logic [TAG_W-1:0] rd_ptr;
   logic [TAG_W-1:0] wr_ptr;

   assign head_tag = slot[rd_ptr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_TAGS; i++) slot[i] <= TAG_W'(i);
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= CNT_W'(NUM_TAGS);
      end else begin
         if (rel_valid) begin
            slot[wr_ptr] <= rel_tag;
            wr_ptr       <= wr_ptr + 1'b1;
         end
         if (alloc) rd_ptr <= rd_ptr + 1'b1;
         count <= count + CNT_W'(rel_valid) - CNT_W'(alloc);
      end
   end

   // R7
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alloc |-> (count != '0));

   // R8
   rel_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rel_valid |-> (count != CNT_W'(NUM_TAGS)));

   // R9
   same_cycle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc && rel_valid) |=> (count == $past(count)));

endmodule

// File: rtl/ren_map_stack.sv
module ren_map_stack #(
   parameter int STACK_DEPTH = 8,
   parameter int TAG_W       = 4,
   parameter int ROT_SPAN    = 3,
   localparam int DEP_W      = $clog2(STACK_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             do_push,
   input  logic             do_pop,
   input  logic             do_swap,
   input  logic             do_rot,
   input  logic             do_bin,
   input  logic [TAG_W-1:0] new_tag,
   output logic [TAG_W-1:0] top_tag,
   output logic [TAG_W-1:0] sec_tag,
   output logic [DEP_W-1:0] depth
);

   generate
      if (STACK_DEPTH < 2) begin : g_bad_depth
         $error("ren_map_stack: STACK_DEPTH must be at least 2");
      end
      if (ROT_SPAN < 2 || ROT_SPAN > STACK_DEPTH) begin : g_bad_rot
         $error("ren_map_stack: ROT_SPAN must lie in 2..STACK_DEPTH");
      end
   endgenerate

   // index 0 is the top of stack
   logic [TAG_W-1:0] ent [STACK_DEPTH];
   logic [TAG_W-1:0] nxt [STACK_DEPTH];

   for (genvar i = 0; i < STACK_DEPTH; i++) begin : g_ent
      logic [TAG_W-1:0] above_v;
      logic [TAG_W-1:0] below_v;
      logic [TAG_W-1:0] swap_v;
      logic [TAG_W-1:0] rot_v;

      if (i == 0) begin : g_a0
         assign above_v = new_tag;
      end else begin : g_an
         assign above_v = ent[i-1];
      end

      if (i == STACK_DEPTH - 1) begin : g_bl
         assign below_v = '0;
      end else begin : g_bn
         assign below_v = ent[i+1];
      end

      if (i == 0) begin : g_s0
         assign swap_v = ent[1];
      end else if (i == 1) begin : g_s1
         assign swap_v = ent[0];
      end else begin : g_sn
         assign swap_v = ent[i];
      end

      if (i == 0) begin : g_r0
         assign rot_v = ent[ROT_SPAN-1];
      end else if (i < ROT_SPAN) begin : g_r1
         assign rot_v = ent[i-1];
      end else begin : g_rn
         assign rot_v = ent[i];
      end

      always_comb begin
         if (do_push)       nxt[i] = above_v;
         else if (do_pop)   nxt[i] = below_v;
         else if (do_swap)  nxt[i] = swap_v;
         else if (do_rot)   nxt[i] = rot_v;
         else if (do_bin)   nxt[i] = (i == 0) ? new_tag : below_v;
         else               nxt[i] = ent[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < STACK_DEPTH; i++) ent[i] <= '0;
         depth <= '0;
      end else begin
         for (int i = 0; i < STACK_DEPTH; i++) ent[i] <= nxt[i];
         if (do_push)               depth <= depth + 1'b1;
         else if (do_pop || do_bin) depth <= depth - 1'b1;
      end
   end

   assign top_tag = ent[0];
   assign sec_tag = ent[1];

   // R7
   depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      depth <= DEP_W'(STACK_DEPTH));

   // R5
   rot_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      do_rot |=> (top_tag == $past(ent[ROT_SPAN-1])) && (sec_tag == $past(ent[0])));

endmodule

// File: rtl/stack_renamer.sv
module stack_renamer
   import stk_ren_pkg::*;
#(
   parameter int NUM_PREGS   = 16,
   parameter int STACK_DEPTH = 8,
   parameter int ROT_SPAN    = 3,
   localparam int TAG_W      = $clog2(NUM_PREGS),
   localparam int DEP_W      = $clog2(STACK_DEPTH + 1),
   localparam int CNT_W      = $clog2(NUM_PREGS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid,
   input  logic [2:0]       op_kind,
   input  logic             rel_valid,
   input  logic [TAG_W-1:0] rel_tag,
   output logic             stall,
   output logic [TAG_W-1:0] src_a_tag,
   output logic [TAG_W-1:0] src_b_tag,
   output logic [TAG_W-1:0] dst_tag,
   output logic             dst_valid,
   output logic [DEP_W-1:0] stack_depth,
   output logic [CNT_W-1:0] free_count
);

   generate
      if (NUM_PREGS <= STACK_DEPTH) begin : g_bad_regs
         $error("stack_renamer: NUM_PREGS must exceed STACK_DEPTH");
      end
   endgenerate

   logic do_push, do_pop, do_swap, do_rot, do_bin;
   logic alloc;

   ren_op_decode #(
      .STACK_DEPTH (STACK_DEPTH),
      .ROT_SPAN    (ROT_SPAN)
   ) u_dec (
      .op_valid (op_valid),
      .op_kind  (op_kind),
      .depth    (stack_depth),
      .fl_empty (free_count == '0),
      .stall    (stall),
      .do_push  (do_push),
      .do_pop   (do_pop),
      .do_swap  (do_swap),
      .do_rot   (do_rot),
      .do_bin   (do_bin)
   );

   assign alloc     = do_push || do_bin;
   assign dst_valid = alloc;

   ren_free_list #(
      .NUM_TAGS (NUM_PREGS)
   ) u_free (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc     (alloc),
      .rel_valid (rel_valid),
      .rel_tag   (rel_tag),
      .head_tag  (dst_tag),
      .count     (free_count)
   );

   ren_map_stack #(
      .STACK_DEPTH (STACK_DEPTH),
      .TAG_W       (TAG_W),
      .ROT_SPAN    (ROT_SPAN)
   ) u_map (
      .clk     (clk),
      .rst_n   (rst_n),
      .do_push (do_push),
      .do_pop  (do_pop),
      .do_swap (do_swap),
      .do_rot  (do_rot),
      .do_bin  (do_bin),
      .new_tag (dst_tag),
      .top_tag (src_a_tag),
      .sec_tag (src_b_tag),
      .depth   (stack_depth)
   );

   // R2
   push_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dst_valid && op_kind == OPK_PUSH) |=> (src_a_tag == $past(dst_tag)));

   // R4
   swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !stall && op_kind == OPK_SWAP) |=>
         (src_a_tag == $past(src_b_tag)) && (src_b_tag == $past(src_a_tag)));

   // R7
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && stall) |=>
         (stack_depth == $past(stack_depth)) && (src_a_tag == $past(src_a_tag)));

endmodule

// File: tb/stack_renamer_test.sv
module stack_renamer_test;

   localparam int CLK_PERIOD = 10;
   localparam int NP = 16;
   localparam int SD = 8;
   localparam int RS = 3;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       op_valid;
   logic [2:0] op_kind;
   logic       rel_valid;
   logic [3:0] rel_tag;
   logic       stall;
   logic [3:0] src_a_tag, src_b_tag, dst_tag;
   logic       dst_valid;
   logic [3:0] stack_depth;
   logic [4:0] free_count;

   stack_renamer #(.NUM_PREGS(NP), .STACK_DEPTH(SD), .ROT_SPAN(RS)) uut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
      .rel_valid(rel_valid), .rel_tag(rel_tag), .stall(stall),
      .src_a_tag(src_a_tag), .src_b_tag(src_b_tag), .dst_tag(dst_tag),
      .dst_valid(dst_valid), .stack_depth(stack_depth), .free_count(free_count)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int    errors = 0;
   int    checks = 0;
   bit    finished = 0;
   int    m_stk [SD];
   int    m_dep = 0;
   int    fq[$];
   int    pool[$];
   string prev_req = "R1";
   string prev_cnt_req = "R1";

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit model_stall(int k);
      case (k)
         1: return (m_dep == SD) || (fq.size() == 0);
         2: return m_dep < 1;
         3: return m_dep < 2;
         4: return m_dep < RS;
         5: return (m_dep < 2) || (fq.size() == 0);
         default: return 1'b0;
      endcase
   endfunction

   function automatic string op_req(int k);
      case (k)
         1: return "R2";
         2: return "R3";
         3: return "R4";
         4: return "R5";
         5: return "R6";
         default: return "R10";
      endcase
   endfunction

   task automatic step(int k, bit rv, int rt);
      bit st, al;
      int t;
      @(negedge clk);
      op_valid  = 1'b1;
      op_kind   = 3'(k);
      rel_valid = rv;
      rel_tag   = 4'(rt);
      #1;
      chk(prev_req, int'(stack_depth), m_dep);
      if (m_dep >= 1) chk(prev_req, int'(src_a_tag), m_stk[0]);
      if (m_dep >= 2) chk(prev_req, int'(src_b_tag), m_stk[1]);
      chk(prev_cnt_req, int'(free_count), fq.size());
      st = model_stall(k);
      chk("R7", int'(stall), int'(st));
      al = !st && (k == 1 || k == 5);
      chk(op_req(k), int'(dst_valid), int'(al));
      if (al) chk(op_req(k), int'(dst_tag), fq[0]);
      if (!st) begin
         case (k)
            1: begin
               for (int i = SD-1; i > 0; i--) m_stk[i] = m_stk[i-1];
               m_stk[0] = fq.pop_front();
               m_dep++;
            end
            2: begin
               pool.push_back(m_stk[0]);
               for (int i = 0; i < SD-1; i++) m_stk[i] = m_stk[i+1];
               m_dep--;
            end
            3: begin
               t = m_stk[0]; m_stk[0] = m_stk[1]; m_stk[1] = t;
            end
            4: begin
               t = m_stk[RS-1];
               for (int i = RS-1; i > 0; i--) m_stk[i] = m_stk[i-1];
               m_stk[0] = t;
            end
            5: begin
               pool.push_back(m_stk[0]);
               pool.push_back(m_stk[1]);
               for (int i = 1; i < SD-1; i++) m_stk[i] = m_stk[i+1];
               m_stk[0] = fq.pop_front();
               m_dep--;
            end
            default: ;
         endcase
      end
      if (rv) fq.push_back(rt);
      prev_req     = st ? "R7" : op_req(k);
      prev_cnt_req = (al && rv) ? "R9" : "R8";
      @(posedge clk);
   endtask

   task automatic step_rel(int k);
      int idx, rt;
      bit rv = 1'b0;
      rt = 0;
      if (pool.size() > 0 && ($urandom % 2) == 1) begin
         idx = int'($urandom % pool.size());
         rt  = pool[idx];
         pool.delete(idx);
         rv  = 1'b1;
      end
      step(k, rv, rt);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      int t;
      void'($urandom(32'd4711));
      rst_n = 1'b0; op_valid = 1'b0; op_kind = 3'd0; rel_valid = 1'b0; rel_tag = 4'd0;
      for (int i = 0; i < NP; i++) fq.push_back(i);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1", int'(stack_depth), 0);
      chk("R1", int'(free_count), NP);
      chk("R1", int'(stall), 0);

      // R2 fill the stack, then overflow stall (R7)
      for (int i = 0; i < SD; i++) step(1, 0, 0);
      step(1, 0, 0);
      // R4, R5, R6, R3, R10
      step(3, 0, 0);
      step(4, 0, 0);
      step(5, 0, 0);
      step(2, 0, 0);
      step(6, 0, 0);
      step(7, 0, 0);
      step(0, 0, 0);
      // drain, then underflow stalls (R7)
      while (m_dep > 0) step(2, 0, 0);
      step(2, 0, 0);
      step(3, 0, 0);
      step(4, 0, 0);
      step(5, 0, 0);
      // exhaust free list (R7 empty)
      while (fq.size() > 0) begin
         step(1, 0, 0);
         step(2, 0, 0);
      end
      step(1, 0, 0);
      // push with release while empty: stalls, tag joins tail (R8)
      t = pool.pop_front();
      step(1, 1, t);
      step(1, 0, 0);
      step(2, 0, 0);
      t = pool.pop_front();
      step(0, 1, t);
      // R9 push and release in the same cycle
      t = pool.pop_front();
      step(1, 1, t);
      step(1, 0, 0);
      // random phase
      for (int n = 0; n < 3000; n++) step_rel(int'($urandom % 8));
      step(0, 0, 0);
      finish_run();
   end

endmodule